// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Unit

This unit watches an 8-bit input port and records active edges on its pins as sticky interrupt flags. Each pin has a polarity bit that selects a rising or a falling edge as active, and an enable bit that decides whether its flag may drive the interrupt line. One interrupt request output is high while any flag is pending on an enabled pin.

Software reaches the enable, polarity and flag registers through a small register bus. Writes take effect on a clock edge, and reads return data combinationally from the address. A flag is cleared by writing a one to its bit. Bit position 3 is not implemented in any register.

Each input crosses a two-stage synchronizer. Edges are then found by comparing the synchronized level with its value one cycle earlier. A flag is set by an edge whether or not its pin is enabled.

Top module: `edge_irq_port`

## Requirements
- R1: Register map on `bus_addr_i`: 0 = enable, 1 = polarity, 2 = flags, 3 = reads all zeros and ignores writes. A write happens on the rising clock edge where `bus_sel_i` and `bus_wr_i` are both high. `bus_rdata_o` follows the addressed register while `bus_sel_i` is high, and is zero otherwise.
- R2: After a synchronous active-low reset, the enable, polarity and flag registers all read 0 and `irq_o` is low.
- R3: Bit 3 of the enable, polarity and flag registers always reads 0, and writes to it are ignored.
- R4: An active edge on pin n sets flag n. The set is visible on the third rising clock edge after the pin changes: two synchronizer stages, then the flag register. It is not visible after the second edge.
- R5: A polarity bit of 1 makes the rising edge active on that pin, and 0 makes the falling edge active. An edge in the opposite direction leaves the flag unchanged.
- R6: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R7: If an active edge and a write-1 clear reach the same flag on the same clock edge, the flag ends up set.
- R8: Flags are set by active edges regardless of the enable bits.
- R9: `irq_o` is high exactly when some bit is set in both the flags and the enable register. Enabling a pin whose flag is already pending raises `irq_o` right after the enabling write.
- R10: Changing a polarity bit while the pin is steady does not set a flag.
- R11: A flag stays set after its pin returns to its former level, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Asynchronous port inputs |
| bus_sel_i | input | 1 | Register bus select |
| bus_wr_i | input | 1 | Write strobe; a read when low |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench presents an edge and a write-1 clear on the same flag in the same cycle. A design that gives the clear priority would silently lose that event. It toggles polarity bits while the pins are steady, which catches a design that detects level mismatches instead of real transitions, because such a design would raise false flags. It checks the flag one cycle before and on the cycle it should appear, which exposes a missing or extra synchronizer stage. It also writes ones and zeros to bit 3 and to the flags, so that a stray implemented bit or a write-zero clear reads back wrong.

// File: rtl/edge_irq_pkg.sv
// Package: shared register-select encoding for the edge interrupt port.
// Assumes a 2-bit register address on the bus.
package edge_irq_pkg;
    typedef enum logic [1:0] {
        REG_ENABLE   = 2'd0,
        REG_POLARITY = 2'd1,
        REG_FLAGS    = 2'd2,
        REG_SPARE    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Brings each asynchronous pin into the clock domain through two flops.
// Assumes each pin is independent; no multi-bit coherence is implied.
module pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift the pin level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_i[b]};
            end
            assign sync_o[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/edge_qualifier.sv
// Module: edge_qualifier
// Finds per-pin transitions of the synchronized level and keeps those whose
// direction matches the polarity bit (1 = rising, 0 = falling).
// Assumes level_i is already synchronous. Detection waits until the
// history register holds a real sample after reset.
module edge_qualifier #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] evt_o
);
    localparam int ARM_W = 2;
    localparam logic [ARM_W-1:0] ARM_DONE = '1;

    logic [W-1:0]     prev_q;
    logic [ARM_W-1:0] arm_q;
    logic [W-1:0]     moved;
    logic [W-1:0]     dir_ok;

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    // Count cycles after reset until the pipeline holds real samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                arm_q <= '0;
        else if (arm_q != ARM_DONE) arm_q <= arm_q + 1'b1;
    end

    // Qualify only real transitions whose new level matches the polarity.
    always_comb begin
        moved  = level_i ^ prev_q;
        dir_ok = ~(level_i ^ pol_i);
        evt_o  = (arm_q == ARM_DONE) ? (moved & dir_ok) : '0;
    end
endmodule

// File: rtl/irq_regfile.sv
// Module: irq_regfile
// Holds the enable, polarity and sticky flag registers, decodes bus
// accesses and forms the interrupt request.
// Assumes evt_i is synchronous; unimplemented bits given by IMPL_MASK.
module irq_regfile
    import edge_irq_pkg::*;
#(
    parameter int           W         = 8,
    parameter logic [W-1:0] IMPL_MASK = 8'hF7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_i,
    input  logic         wr_i,
    input  logic [1:0]   addr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] evt_i,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] flags_o,
    output logic [W-1:0] rdata_o,
    output logic         irq_o
);
    logic [W-1:0] en_q, pol_q, flag_q;
    logic [W-1:0] clr;
    logic         wr_hit;
    reg_sel_e     sel_reg;

    // Decode the bus access.
    always_comb begin
        sel_reg = reg_sel_e'(addr_i);
        wr_hit  = sel_i & wr_i;
        clr     = (wr_hit && sel_reg == REG_FLAGS) ? wdata_i : '0;
    end

    // Enable and polarity registers, implemented bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
        end else if (wr_hit) begin
            if (sel_reg == REG_ENABLE)   en_q  <= wdata_i & IMPL_MASK;
            if (sel_reg == REG_POLARITY) pol_q <= wdata_i & IMPL_MASK;
        end
    end

    // Sticky flags: write-one clears, a same-cycle edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= ((flag_q & ~clr) | evt_i) & IMPL_MASK;
    end

    // Read mux and interrupt request.
    always_comb begin
        rdata_o = '0;
        if (sel_i) begin
            case (sel_reg)
                REG_ENABLE:   rdata_o = en_q;
                REG_POLARITY: rdata_o = pol_q;
                REG_FLAGS:    rdata_o = flag_q;
                default:      rdata_o = '0;
            endcase
        end
        irq_o = |(flag_q & en_q);
    end

    assign pol_o   = pol_q;
    assign flags_o = flag_q;

    // R2: registers are clear on the first cycle after reset.
    p_reset_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (flag_q == '0 && en_q == '0 && pol_q == '0 && !irq_o));

    // R3: unimplemented positions never hold a one.
    p_spare_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q | pol_q | flag_q) & ~IMPL_MASK) == '0);

    // R4: a flag only rises when an edge event was present.
    p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flag_q & ~$past(flag_q) & ~$past(evt_i)) == '0));

    // R6: a write-one clear without a competing edge empties the bit.
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(clr) & ~$past(evt_i) & flag_q) == '0));

    // R7: an edge event always leaves its flag set.
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(evt_i) & IMPL_MASK & ~flag_q) == '0));
endmodule

// File: rtl/edge_irq_port.sv
// Module: edge_irq_port (top)
// Edge-triggered port interrupt unit: synchronizes the pins, qualifies
// edges by per-pin polarity and keeps sticky, maskable interrupt flags.
// Assumes pins are asynchronous and held at least two clock cycles.
module edge_irq_port #(
    parameter int           PORT_W    = 8,
    parameter logic [PORT_W-1:0] IMPL_MASK = 8'hF7,
    parameter int           SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [PORT_W-1:0] bus_wdata_i,
    output logic [PORT_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    logic [PORT_W-1:0] level;
    logic [PORT_W-1:0] evt;
    logic [PORT_W-1:0] pol;
    logic [PORT_W-1:0] flags;

    pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (level)
    );

    edge_qualifier #(.W(PORT_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level),
        .pol_i   (pol),
        .evt_o   (evt)
    );

    irq_regfile #(.W(PORT_W), .IMPL_MASK(IMPL_MASK)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (bus_sel_i),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .evt_i   (evt),
        .pol_o   (pol),
        .flags_o (flags),
        .rdata_o (bus_rdata_o),
        .irq_o   (irq_o)
    );

    // R5: a newly set flag follows a level that matches its polarity.
    p_pol_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags & ~$past(flags) & ($past(level) ^ $past(pol))) == '0));

    // R3: bit 3 of read data is always zero.
    p_rdata_spare_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_o & ~IMPL_MASK) == '0);
endmodule

// File: tb/edge_irq_port_bench.sv
module edge_irq_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin = 8'h00;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Vector fields: {polarity, pins before, pins after, expected flags}
    localparam logic [31:0] VEC [0:6] = '{
        32'h00FF00F7, 32'hFF00FFF7, 32'hFFFF0000, 32'h0F00FF07,
        32'h0FFF00F0, 32'hA55AA5F7, 32'h3C0FF033
    };

    edge_irq_port u_edge_irq_port (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        bus_read(2'd0, v); check("R2 enable after reset", v, 8'h00);
        bus_read(2'd1, v); check("R2 polarity after reset", v, 8'h00);
        bus_read(2'd2, v); check("R2 flags after reset", v, 8'h00);
        bus_read(2'd3, v); check("R1 spare address reads zero", v, 8'h00);
        check("R2 irq after reset", {7'd0, irq}, 8'h00);

        // R3: bit 3 unimplemented
        bus_write(2'd0, 8'hFF); bus_read(2'd0, v); check("R3 enable bit3", v, 8'hF7);
        bus_write(2'd1, 8'hFF); bus_read(2'd1, v); check("R3 polarity bit3", v, 8'hF7);
        bus_write(2'd3, 8'hFF); bus_read(2'd3, v); check("R1 spare write ignored", v, 8'h00);
        bus_write(2'd0, 8'h00);

        // R5 / R1: vector table walk
        foreach (VEC[i]) begin
            bus_write(2'd1, VEC[i][31:24]);
            @(negedge clk); pin = VEC[i][23:16];
            wait_cycles(5);
            bus_write(2'd2, 8'hFF);
            @(negedge clk); pin = VEC[i][15:8];
            wait_cycles(5);
            bus_read(2'd2, v);
            check($sformatf("R5 vector %0d flags", i), v, VEC[i][7:0]);
        end

        // R8 / R11: flags with enables off, sticky after return
        bus_write(2'd1, 8'h00);
        @(negedge clk); pin = 8'hFF;
        wait_cycles(5);
        bus_write(2'd2, 8'hFF);
        @(negedge clk); pin = 8'h00;
        wait_cycles(5);
        bus_read(2'd2, v); check("R8 flags set with enables off", v, 8'hF7);
        check("R8 irq masked", {7'd0, irq}, 8'h00);
        @(negedge clk); pin = 8'hFF;
        wait_cycles(5);
        bus_read(2'd2, v); check("R11 flags sticky", v, 8'hF7);

        // R6: write-one clear
        bus_write(2'd2, 8'h00); bus_read(2'd2, v); check("R6 write zero keeps", v, 8'hF7);
        bus_write(2'd2, 8'h05); bus_read(2'd2, v); check("R6 write one clears", v, 8'hF2);

        // R9: irq from flags and enables
        bus_write(2'd0, 8'h01); check("R9 enabled pin without flag", {7'd0, irq}, 8'h00);
        bus_write(2'd0, 8'h02); check("R9 enabling pending flag", {7'd0, irq}, 8'h01);
        bus_write(2'd2, 8'h02); check("R9 irq drops on clear", {7'd0, irq}, 8'h00);
        bus_write(2'd0, 8'h00);

        // R10: polarity change on steady pins
        @(negedge clk); pin = 8'h00;
        wait_cycles(5);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd1, 8'hFF);
        wait_cycles(5);
        bus_read(2'd2, v); check("R10 no flag from polarity to rising", v, 8'h00);
        bus_write(2'd1, 8'h00);
        wait_cycles(5);
        bus_read(2'd2, v); check("R10 no flag from polarity to falling", v, 8'h00);

        // R7: edge and clear on the same clock edge
        bus_write(2'd1, 8'hFF);
        @(negedge clk); pin = 8'h01;
        @(negedge clk);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 2'd2; wdata = 8'h01;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        bus_read(2'd2, v); check("R7 set wins over clear", v, 8'h01);
        bus_write(2'd2, 8'h01); bus_read(2'd2, v); check("R7 later clear works", v, 8'h00);

        // R4: latency of flag setting
        bus_write(2'd1, 8'h00);
        wait_cycles(2);
        @(negedge clk); pin = 8'h00;
        @(negedge clk);
        @(negedge clk);
        bus_read(2'd2, v); check("R4 flag not after two edges", v, 8'h00);
        @(negedge clk);
        bus_read(2'd2, v); check("R4 flag after three edges", v, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule